// File: doc/BRIEF.md
# Quarter-Duty LCD Multiplex Drive Sequencer

This block produces the drive codes for a multiplexed liquid-crystal panel with four common electrodes and thirty-two segment electrodes, run at 1/4 duty and 1/3 bias. A prescaler divides the incoming timing clock, which is nominally around 18 kHz. Its output steps a common counter through the four common phases. After each full pass of the four phases, a frame polarity bit toggles, so that the panel sees no net DC voltage.

Every common and segment output is a 2-bit code. The code picks one of four analog rails, which the surrounding analog circuitry provides: VDD, V1 (one third of the drive voltage below VDD), V2 (two thirds below VDD) and V3 (the full drive voltage below VDD). The segment codes come from a 128-bit pixel map, one bit per panel dot. A small mode register can override the map to force every segment on or off without altering the map, and can return the panel to showing the map.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: After reset the phase is 0, the polarity is A (0), and the mode is all-off. So common 0 drives code 3, the other commons drive code 1, and every segment drives code 2, whatever the pixel map holds.
- R2: The phase holds for PRESCALE clock cycles and then advances by one, in the order 0,1,2,3,0. On phase_o the new value appears PRESCALE cycles after the previous change (the first change comes PRESCALE cycles after reset).
- R3: The polarity changes exactly when the phase wraps from 3 to 0, and at no other time.
- R4: Level codes are 0=VDD, 1=V1, 2=V2, 3=V3, with 2 bits per output and output k at bits [2k+1:2k]. In polarity A the common matching the phase drives 3 and the others drive 1. In polarity B the matching common drives 0 and the others drive 2.
- R5: In normal mode (code 0), segment n is on when pixel_map_i bit n*4+phase is 1. In polarity A an on segment drives 0 and an off segment drives 2. In polarity B an on segment drives 3 and an off segment drives 1.
- R6: A mode write of code 1 (all-on) makes every segment drive its on level from the next cycle, and code 2 (all-off) makes every segment drive its off level, regardless of the pixel map.
- R7: A mode write of code 0 after all-on or all-off shows the unchanged pixel map again from the next cycle.
- R8: A mode write with code 3 is ignored: the segment outputs keep following the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_i | input | 1 | Strobe to load mode_code_i |
| mode_code_i | input | 2 | 0 normal, 1 all-on, 2 all-off, 3 ignored |
| pixel_map_i | input | 128 | Pixel bits, bit n*4+k for segment n in phase k |
| com_lvl_o | output | 8 | Level codes of the four commons |
| seg_lvl_o | output | 64 | Level codes of the 32 segments |
| phase_o | output | 2 | Current common phase |
| polarity_o | output | 1 | Frame polarity, 0 = A, 1 = B |

## Verification
Every cycle, the assertions check the timer's stepping rules: the phase holds between prescaler ends, it steps by one, and the polarity flips only on the wrap. They also check that exactly one common is at the selected level, that segment codes stay within the pair allowed for the current polarity, and that a write of the reserved mode code leaves the mode alone. Only the bench's scenarios show the absolute phase and polarity sequence measured from reset, and the mapping from pixel-map bits to segments. The same holds for the restoration of the map after an override, and for the override behaviour under random pixel maps and random mode writes.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        LVL_VDD = 2'd0,
        LVL_V1  = 2'd1,
        LVL_V2  = 2'd2,
        LVL_V3  = 2'd3
    } lvl_e;

    localparam logic [1:0] MODE_NORMAL  = 2'd0;
    localparam logic [1:0] MODE_ALL_ON  = 2'd1;
    localparam logic [1:0] MODE_ALL_OFF = 2'd2;
    localparam logic [1:0] MODE_RSVD    = 2'd3;

    // level driven by a common electrode
    function automatic lvl_e com_level(input logic sel, input logic pol);
        if (!pol) return sel ? LVL_V3 : LVL_V1;
        return sel ? LVL_VDD : LVL_V2;
    endfunction

    // level driven by a segment electrode
    function automatic lvl_e seg_level(input logic on, input logic pol);
        if (!pol) return on ? LVL_VDD : LVL_V2;
        return on ? LVL_V3 : LVL_V1;
    endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
    parameter int PRESCALE = 45,
    parameter int NCOM     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [$clog2(NCOM)-1:0]   phase_o,
    output logic                      pol_o
);
    localparam int PH_W  = $clog2(NCOM);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] LAST_PRE = PRE_W'(PRESCALE - 1);
    localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(NCOM - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [PH_W-1:0]  phase;
        logic             pol;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pre == LAST_PRE) begin
            st_d.pre = '0;
            if (st_q.phase == LAST_PH) begin
                st_d.phase = '0;
                st_d.pol   = ~st_q.pol;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.phase;
    assign pol_o   = st_q.pol;

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pre != LAST_PRE) |=> $stable(st_q.phase)); // R2
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pre == LAST_PRE && st_q.phase != LAST_PH)
        |=> (st_q.phase == PH_W'($past(st_q.phase) + 1'b1))); // R2
    AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pre == LAST_PRE && st_q.phase == LAST_PH)
        |=> (st_q.phase == '0 && st_q.pol != $past(st_q.pol))); // R3
    AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.pre == LAST_PRE && st_q.phase == LAST_PH) |=> $stable(st_q.pol)); // R3
endmodule

// File: rtl/lcd_mode_reg.sv
module lcd_mode_reg
    import lcd_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr_i,
    input  logic [1:0] mode_code_i,
    output logic [1:0] mode_o
);
    logic [1:0] mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (mode_wr_i && mode_code_i != MODE_RSVD) mode_d = mode_code_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_ALL_OFF;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;

    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i && mode_code_i == MODE_RSVD) |=> $stable(mode_q)); // R8
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i && mode_code_i != MODE_RSVD) |=> (mode_q == $past(mode_code_i))); // R6
endmodule

// File: rtl/lcd_com_bank.sv
module lcd_com_bank
    import lcd_seq_pkg::*;
#(
    parameter int NCOM = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NCOM)-1:0] phase_i,
    input  logic                    pol_i,
    output logic [2*NCOM-1:0]       com_lvl_o
);
    localparam int PH_W = $clog2(NCOM);

    logic [NCOM-1:0] at_sel_lvl;
    lvl_e            sel_lvl;

    assign sel_lvl = com_level(1'b1, pol_i);

    for (genvar k = 0; k < NCOM; k++) begin : g_com
        logic sel;
        assign sel                  = (phase_i == PH_W'(k));
        assign com_lvl_o[2*k +: 2]  = com_level(sel, pol_i);
        assign at_sel_lvl[k]        = (com_lvl_o[2*k +: 2] == sel_lvl);
    end

    AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(at_sel_lvl) == 1); // R4
endmodule

// File: rtl/lcd_seg_bank.sv
module lcd_seg_bank
    import lcd_seq_pkg::*;
#(
    parameter int NCOM = 4,
    parameter int NSEG = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSEG*NCOM-1:0]    pixel_map_i,
    input  logic [$clog2(NCOM)-1:0] phase_i,
    input  logic                    pol_i,
    input  logic [1:0]              mode_i,
    output logic [2*NSEG-1:0]       seg_lvl_o
);
    logic [NSEG-1:0] odd_code;
    logic [NSEG-1:0] at_off;

    for (genvar n = 0; n < NSEG; n++) begin : g_seg
        logic [NCOM-1:0] col;
        logic            on;
        assign col = pixel_map_i[n*NCOM +: NCOM];
        always_comb begin
            unique case (mode_i)
                MODE_ALL_ON:  on = 1'b1;
                MODE_ALL_OFF: on = 1'b0;
                default:      on = col[phase_i];
            endcase
        end
        assign seg_lvl_o[2*n +: 2] = seg_level(on, pol_i);
        assign odd_code[n]         = seg_lvl_o[2*n];
        assign at_off[n]           = (seg_lvl_o[2*n +: 2] == seg_level(1'b0, pol_i));
    end

    AST_SEG_PAIR_A: assert property (@(posedge clk) disable iff (!rst_n)
        !pol_i |-> (odd_code == '0)); // R5
    AST_SEG_PAIR_B: assert property (@(posedge clk) disable iff (!rst_n)
        pol_i |-> (&odd_code)); // R5
    AST_FORCED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_ALL_OFF) |-> (&at_off)); // R6
    AST_FORCED_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_ALL_ON) |-> (at_off == '0)); // R6
endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
    import lcd_seq_pkg::*;
#(
    parameter int PRESCALE = 45,
    parameter int NCOM     = 4,
    parameter int NSEG     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_wr_i,
    input  logic [1:0]              mode_code_i,
    input  logic [NSEG*NCOM-1:0]    pixel_map_i,
    output logic [2*NCOM-1:0]       com_lvl_o,
    output logic [2*NSEG-1:0]       seg_lvl_o,
    output logic [$clog2(NCOM)-1:0] phase_o,
    output logic                    polarity_o
);
    logic [$clog2(NCOM)-1:0] phase_w;
    logic                    pol_w;
    logic [1:0]              mode_w;

    lcd_phase_timer #(.PRESCALE(PRESCALE), .NCOM(NCOM)) u_timer (
        .clk(clk), .rst_n(rst_n), .phase_o(phase_w), .pol_o(pol_w)
    );

    lcd_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr_i),
        .mode_code_i(mode_code_i), .mode_o(mode_w)
    );

    lcd_com_bank #(.NCOM(NCOM)) u_com (
        .clk(clk), .rst_n(rst_n), .phase_i(phase_w), .pol_i(pol_w),
        .com_lvl_o(com_lvl_o)
    );

    lcd_seg_bank #(.NCOM(NCOM), .NSEG(NSEG)) u_seg (
        .clk(clk), .rst_n(rst_n), .pixel_map_i(pixel_map_i), .phase_i(phase_w),
        .pol_i(pol_w), .mode_i(mode_w), .seg_lvl_o(seg_lvl_o)
    );

    assign phase_o    = phase_w;
    assign polarity_o = pol_w;
endmodule

// File: tb/lcd_mux_sequencer_tb_top.sv
module lcd_mux_sequencer_tb_top;
    localparam int P    = 5;
    localparam int NCOM = 4;
    localparam int NSEG = 32;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 mode_wr = 1'b0;
    logic [1:0]           mode_code = 2'd0;
    logic [NSEG*NCOM-1:0] pmap = '1;
    logic [2*NCOM-1:0]    com_lvl;
    logic [2*NSEG-1:0]    seg_lvl;
    logic [1:0]           phase;
    logic                 pol;

    int checks = 0;
    int errors = 0;
    int cnt    = 0;
    bit done   = 0;
    logic [1:0] mdl_mode = 2'd2;

    always #10 clk = ~clk;

    lcd_mux_sequencer #(.PRESCALE(P), .NCOM(NCOM), .NSEG(NSEG)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr), .mode_code_i(mode_code),
        .pixel_map_i(pmap), .com_lvl_o(com_lvl), .seg_lvl_o(seg_lvl),
        .phase_o(phase), .polarity_o(pol)
    );

    always @(posedge clk) if (rst_n) cnt <= cnt + 1;

    function automatic logic [1:0] exp_phase(input int c);
        return 2'((c / P) % NCOM);
    endfunction

    function automatic logic exp_pol(input int c);
        return 1'((c / (P * NCOM)) % 2);
    endfunction

    function automatic logic [2*NCOM-1:0] exp_com(input logic [1:0] ph, input logic pl);
        logic [2*NCOM-1:0] v;
        for (int k = 0; k < NCOM; k++) begin
            if (!pl) v[2*k +: 2] = (ph == 2'(k)) ? 2'd3 : 2'd1;
            else     v[2*k +: 2] = (ph == 2'(k)) ? 2'd0 : 2'd2;
        end
        return v;
    endfunction

    function automatic logic [2*NSEG-1:0] exp_seg(input logic [NSEG*NCOM-1:0] m,
            input logic [1:0] md, input logic [1:0] ph, input logic pl);
        logic [2*NSEG-1:0] v;
        logic on;
        for (int n = 0; n < NSEG; n++) begin
            if (md == 2'd1)      on = 1'b1;
            else if (md == 2'd2) on = 1'b0;
            else                 on = m[n*NCOM + int'(ph)];
            if (!pl) v[2*n +: 2] = on ? 2'd0 : 2'd2;
            else     v[2*n +: 2] = on ? 2'd3 : 2'd1;
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string segtag);
        logic [1:0] ph = exp_phase(cnt);
        logic       pl = exp_pol(cnt);
        chk("R2 phase", 128'(phase), 128'(ph));
        chk("R3 polarity", 128'(pol), 128'(pl));
        chk("R4 commons", 128'(com_lvl), 128'(exp_com(ph, pl)));
        chk(segtag, 128'(seg_lvl), 128'(exp_seg(pmap, mdl_mode, ph, pl)));
    endtask

    // drive a mode write at a negedge; after return the next posedge has taken it
    task automatic write_mode(input logic [1:0] code);
        mode_wr = 1'b1;
        mode_code = code;
        @(negedge clk);
        mode_wr = 1'b0;
        if (code != 2'd3) mdl_mode = code;
        #1;
    endtask

    function automatic string seg_tag(input logic [1:0] md);
        return (md == 2'd0) ? "R5 segments" : "R6 segments";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state with all pixels set
        chk("R1 phase", 128'(phase), 128'(0));
        chk("R1 polarity", 128'(pol), 128'(0));
        chk("R1 commons", 128'(com_lvl), 128'(8'b01_01_01_11));
        chk("R1 segments", 128'(seg_lvl), {64'd0, {32{2'd2}}});

        // R2 phase holds until the prescaler ends
        repeat (P - 1) @(negedge clk);
        #1 chk("R2 hold", 128'(phase), 128'(0));
        @(negedge clk); #1 chk("R2 step", 128'(phase), 128'(1));

        // R6 all-on over a map with alternate bits
        pmap = {32{4'b0101}};
        @(negedge clk);
        write_mode(2'd1);
        check_all("R6 all-on");
        // R8 reserved code ignored
        @(negedge clk);
        write_mode(2'd3);
        check_all("R8 reserved");
        chk("R8 still on", 128'(seg_lvl[1:0]), 128'(pol ? 2'd3 : 2'd0));
        // R7 normal shows the map again
        @(negedge clk);
        write_mode(2'd0);
        check_all("R7 restore");
        // R6 all-off
        @(negedge clk);
        write_mode(2'd2);
        check_all("R6 all-off");
        @(negedge clk);
        write_mode(2'd0);
        check_all("R7 restore after off");

        // walk to the first polarity wrap (R3)
        while (cnt < P * NCOM + 1) begin
            @(negedge clk); #1 check_all(seg_tag(mdl_mode));
        end

        // random map and mode traffic
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(7) == 0) pmap = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(15) == 0) begin
                logic [1:0] c = 2'($urandom_range(3));
                write_mode(c);
                check_all(c == 2'd3 ? "R8 random" : seg_tag(mdl_mode));
            end else begin
                #1 check_all(seg_tag(mdl_mode));
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule